// File: doc/BRIEF.md
# Mode-Aware Command Register Bank

This block is the byte-wide register file that sits behind a converter's serial host interface. It holds four registers: a 16-bit command word, a 24-bit output data word, a 24-bit offset calibration word and a 24-bit full-scale calibration word. The host opens a transfer by giving a start address, a byte count and a read/write flag. It then strobes bytes one at a time. After each byte the address steps up or down, as the command word selects. The address stops at either end of the map and does not wrap.

The command word holds a sleep/normal mode flag and two action bits. One action bit clears the data word. The other reloads both calibration words with their preset values. The two modes treat these bits differently:

- **Sleep mode:** the action bits are plain storage and have no side effect.
- **Normal mode:** writing a 1 fires the action at once, and the bit then reads back 0.
- **Switching to normal:** an action bit that is pending, or that is set by the same byte that clears the sleep flag, fires at that moment.

Command-word writes always run in ascending order, most significant byte first. Reads of the command word follow the direction bit.

Top module: `cmd_reg_bank`

## Requirements
- R1: After reset the command word reads 2000h, the data word 000000h, the offset calibration word 000000h and the full-scale calibration word 800000h. The block starts in normal mode and `busy` is low.
- R2: Byte addresses 0–2 hold the data word, 4–5 the command word, 8–10 the offset calibration word and 12–14 the full-scale calibration word. In every case the lowest address holds the most significant byte. Every other address reads 00h, and writes to it change nothing.
- R3: Command-word bits 15, 14, 9, 7, 6, 5, 4, 3 and 0 can be written. Bit 0 is the sleep flag (1 = sleep, 0 = normal), bit 9 is calibration-reset, bit 6 is data-clear and bit 3 is the address direction. Bit 13 always reads 1. Bits 12, 11, 10, 8, 2 and 1 always read 0.
- R4: A `start` pulse loads the address, the byte count and the read/write flag. Each `byte_stb` moves one byte while bytes remain. `busy` is high exactly while bytes remain. A strobe that comes when no bytes remain has no effect.
- R5: With direction bit 3 at 0 the address increments after each byte. With bit 3 at 1 it decrements. This applies to data and calibration accesses and to command-word reads.
- R6: A byte written to address 4 or 5 always steps the address up, whatever bit 3 holds.
- R7: The address holds at 0 when it would decrement below 0, and holds at 15 when it would increment past 15.
- R8: In normal mode, writing address 4 with bit 1 of the byte set (command bit 9) loads the offset word with 000000h and the full-scale word with 800000h. Command bit 9 then reads 0, and the new values are visible in the next cycle.
- R9: In normal mode, writing address 5 with bit 6 of the byte set loads the data word with 000000h. Command bit 6 then reads 0.
- R10: In sleep mode, command bits 9 and 6 read back as written. Writing them leaves the data and calibration words unchanged.
- R11: A write to address 5 with bit 0 of the byte clear always leaves bits 9 and 6 of the command word at 0. If the block was in sleep mode with bit 9 stored as 1, the calibration reload of R8 fires. If the byte has bit 6 set, the data clear of R9 fires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opens a transfer; takes priority over `byte_stb` |
| start_addr | input | AW | First byte address of the transfer |
| start_cnt | input | CNT_W | Number of bytes in the transfer |
| start_wr | input | 1 | 1 = write transfer, 0 = read transfer |
| byte_stb | input | 1 | Moves one byte at the current address |
| wbyte | input | 8 | Write byte |
| rbyte | output | 8 | Byte at the current address |
| busy | output | 1 | Bytes remain in the current transfer |
| cmd_word | output | 16 | Command word as read back |
| data_word | output | 24 | Data word |
| ofs_cal | output | 24 | Offset calibration word |
| fs_cal | output | 24 | Full-scale calibration word |

## Verification
The bench targets the places where the mode rules meet the address rules.

- **Command write with decrement selected:** it writes the command word while the direction bit is 1. A design that applied the direction bit here would send the low byte to the unmapped address 3 and leave the old low byte in place.
- **Mode switch with a stored action:** it leaves the block in sleep with calibration-reset stored, then writes a low byte that clears the sleep flag. A design that only acted on fresh writes would leave both calibration words unreset.
- **Data clear and sleep flag in one byte:** it sets data-clear in the same byte that switches to normal mode. A design that evaluated the action against the old mode would miss that clear.
- **Map ends and unmapped holes:** it runs reads and writes past both ends of the map and into unmapped addresses. Wrapping would corrupt the other end of the map, and an undecoded hole would return stale bytes instead of 00h.

// File: rtl/cmd_reg_bank.sv
`timescale 1ns/1ps
module cmd_reg_bank #(
  parameter int AW    = 4,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    start_addr,
  input  logic [CNT_W-1:0] start_cnt,
  input  logic             start_wr,
  input  logic             byte_stb,
  input  logic [7:0]       wbyte,
  output logic [7:0]       rbyte,
  output logic             busy,
  output logic [15:0]      cmd_word,
  output logic [23:0]      data_word,
  output logic [23:0]      ofs_cal,
  output logic [23:0]      fs_cal
);
  localparam logic [AW-1:0] A_MAX   = {AW{1'b1}};
  localparam logic [15:0]   WR_MASK = 16'hC2F9;
  localparam logic [15:0]   FIXED1  = 16'h2000;
  localparam logic [23:0]   FS_INIT = 24'h800000;

  logic [AW-1:0]    addr;
  logic [CNT_W-1:0] left;
  logic             is_wr;
  logic [15:0]      cmd_q;

  wire sleep   = cmd_q[0];
  wire go      = byte_stb && !start && busy;
  wire wr_go   = go && is_wr;
  wire cmd_hit = (addr == AW'(4)) || (addr == AW'(5));
  wire step_up = (is_wr && cmd_hit) || !cmd_q[3];

  wire [AW-1:0] addr_nx = step_up ? ((addr == A_MAX) ? addr : addr + 1'b1)
                                  : ((addr == '0)    ? addr : addr - 1'b1);

  assign busy     = (left != '0);
  assign cmd_word = (cmd_q & WR_MASK) | FIXED1;

  always_comb begin
    case (addr)
      AW'(0):  rbyte = data_word[23:16];
      AW'(1):  rbyte = data_word[15:8];
      AW'(2):  rbyte = data_word[7:0];
      AW'(4):  rbyte = cmd_word[15:8];
      AW'(5):  rbyte = cmd_word[7:0];
      AW'(8):  rbyte = ofs_cal[23:16];
      AW'(9):  rbyte = ofs_cal[15:8];
      AW'(10): rbyte = ofs_cal[7:0];
      AW'(12): rbyte = fs_cal[23:16];
      AW'(13): rbyte = fs_cal[15:8];
      AW'(14): rbyte = fs_cal[7:0];
      default: rbyte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr  <= '0;
      left  <= '0;
      is_wr <= 1'b0;
    end else if (start) begin
      addr  <= start_addr;
      left  <= start_cnt;
      is_wr <= start_wr;
    end else if (go) begin
      addr  <= addr_nx;
      left  <= left - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      data_word <= '0;
      ofs_cal   <= '0;
      fs_cal    <= FS_INIT;
    end else if (wr_go) begin
      case (addr)
        AW'(0):  data_word[23:16] <= wbyte;
        AW'(1):  data_word[15:8]  <= wbyte;
        AW'(2):  data_word[7:0]   <= wbyte;
        AW'(4): begin
          cmd_q[15:14] <= wbyte[7:6];
          if (!sleep && wbyte[1]) begin
            ofs_cal  <= '0;
            fs_cal   <= FS_INIT;
            cmd_q[9] <= 1'b0;
          end else begin
            cmd_q[9] <= wbyte[1];
          end
        end
        AW'(5): begin
          cmd_q[7]   <= wbyte[7];
          cmd_q[5:3] <= wbyte[5:3];
          cmd_q[0]   <= wbyte[0];
          if (!wbyte[0]) begin
            if (cmd_q[9]) begin
              ofs_cal <= '0;
              fs_cal  <= FS_INIT;
            end
            if (wbyte[6]) data_word <= '0;
            cmd_q[9] <= 1'b0;
            cmd_q[6] <= 1'b0;
          end else begin
            cmd_q[6] <= wbyte[6];
          end
        end
        AW'(8):  ofs_cal[23:16] <= wbyte;
        AW'(9):  ofs_cal[15:8]  <= wbyte;
        AW'(10): ofs_cal[7:0]   <= wbyte;
        AW'(12): fs_cal[23:16]  <= wbyte;
        AW'(13): fs_cal[15:8]   <= wbyte;
        AW'(14): fs_cal[7:0]    <= wbyte;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cmd_reg_bank_chk.sv
`timescale 1ns/1ps
module cmd_reg_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic [15:0] cmd_word,
  input logic [23:0] data_word,
  input logic [23:0] ofs_cal,
  input logic [23:0] fs_cal
);
  assert_reserved_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_word[13] && (cmd_word[12:10] == 3'b000) && !cmd_word[8] && (cmd_word[2:1] == 2'b00));

  assert_normal_actions_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_word[0] |-> (!cmd_word[9] && !cmd_word[6]));

  assert_switch_reloads_cal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cmd_word[0]) && $past(cmd_word[9])) |-> (ofs_cal == 24'h0 && fs_cal == 24'h800000));

  assert_idle_no_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(cmd_word) && $stable(data_word) && $stable(ofs_cal) && $stable(fs_cal)));
endmodule

bind cmd_reg_bank cmd_reg_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cmd_word(cmd_word),
  .data_word(data_word), .ofs_cal(ofs_cal), .fs_cal(fs_cal)
);

// File: tb/tb_cmd_reg_bank.sv
`timescale 1ns/1ps
module tb_cmd_reg_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, start_wr = 1'b0, byte_stb = 1'b0;
  logic [3:0] start_addr = '0, start_cnt = '0;
  logic [7:0] wbyte = '0, rbyte;
  logic       busy;
  logic [15:0] cmd_word;
  logic [23:0] data_word, ofs_cal, fs_cal;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cmd_reg_bank dut (.*);

  // behavioural reference state
  logic [15:0] m_cmd;
  logic [23:0] m_data, m_ofs, m_fs;
  int m_addr, m_left;
  bit m_wr;

  function automatic logic [7:0] m_rd(input int a);
    case (a)
      0: return m_data[23:16];  1: return m_data[15:8];  2: return m_data[7:0];
      4: return m_cmd[15:8];    5: return m_cmd[7:0];
      8: return m_ofs[23:16];   9: return m_ofs[15:8];   10: return m_ofs[7:0];
      12: return m_fs[23:16];   13: return m_fs[15:8];   14: return m_fs[7:0];
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_write(input int a, input logic [7:0] b);
    bit s, b9, b6;
    case (a)
      0: m_data[23:16] = b;  1: m_data[15:8] = b;  2: m_data[7:0] = b;
      8: m_ofs[23:16] = b;   9: m_ofs[15:8] = b;   10: m_ofs[7:0] = b;
      12: m_fs[23:16] = b;   13: m_fs[15:8] = b;   14: m_fs[7:0] = b;
      4: begin
        b9 = b[1];
        if (!m_cmd[0] && b[1]) begin m_ofs = 0; m_fs = 24'h800000; b9 = 0; end
        m_cmd[15:8] = {b[7:6], 1'b1, 3'b000, b9, 1'b0};
      end
      5: begin
        s = b[0]; b6 = b[6];
        if (!s) begin
          if (m_cmd[9]) begin m_ofs = 0; m_fs = 24'h800000; end
          if (b[6]) m_data = 0;
          m_cmd[9] = 0; b6 = 0;
        end
        m_cmd[7:0] = {b[7], b6, b[5:3], 2'b00, s};
      end
      default: ;
    endcase
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cmd = 16'h2000; m_data = 0; m_ofs = 0; m_fs = 24'h800000;
      m_addr = 0; m_left = 0; m_wr = 0;
    end else if (start) begin
      m_addr = start_addr; m_left = start_cnt; m_wr = start_wr;
    end else if (byte_stb && m_left > 0) begin
      bit up;
      up = (m_wr && (m_addr == 4 || m_addr == 5)) || !m_cmd[3];
      if (m_wr) m_write(m_addr, wbyte);
      if (up) begin if (m_addr < 15) m_addr++; end
      else    begin if (m_addr > 0)  m_addr--; end
      m_left--;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      chk("model rbyte", {24'h0, rbyte}, {24'h0, m_rd(m_addr)});
      chk("model busy", {31'h0, busy}, {31'h0, m_left > 0});
      chk("model cmd", {16'h0, cmd_word}, {16'h0, m_cmd});
      chk("model data", {8'h0, data_word}, {8'h0, m_data});
      chk("model ofs", {8'h0, ofs_cal}, {8'h0, m_ofs});
      chk("model fs", {8'h0, fs_cal}, {8'h0, m_fs});
    end
    if (cycles > 200000 && !done) begin
      done = 1; bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=<200000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic xfer(input int a, input int n, input bit w);
    start = 1; start_addr = 4'(a); start_cnt = 4'(n); start_wr = w;
    @(negedge clk); start = 0;
  endtask

  task automatic put(input logic [7:0] b);
    byte_stb = 1; wbyte = b;
    @(negedge clk); byte_stb = 0;
  endtask

  task automatic get(output logic [7:0] b);
    b = rbyte; byte_stb = 1;
    @(negedge clk); byte_stb = 0;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 cmd", cmd_word, 16'h2000);
    chk("R1 data", data_word, 0);
    chk("R1 ofs", ofs_cal, 0);
    chk("R1 fs", fs_cal, 24'h800000);
    chk("R1 busy", busy, 0);

    xfer(0, 3, 1);
    chk("R4 busy during transfer", busy, 1);
    put(8'hA1); put(8'hB2); put(8'hC3);
    chk("R2 data write", data_word, 24'hA1B2C3);
    chk("R4 busy after count", busy, 0);
    put(8'hFF);
    chk("R4 stray strobe ignored", data_word, 24'hA1B2C3);

    xfer(8, 3, 1);  put(8'h12); put(8'h34); put(8'h56);
    chk("R2 ofs write", ofs_cal, 24'h123456);
    xfer(12, 3, 1); put(8'h65); put(8'h43); put(8'h21);
    chk("R2 fs write", fs_cal, 24'h654321);

    xfer(4, 2, 1); put(8'hFF); put(8'hFF);
    chk("R8 ofs reset", ofs_cal, 0);
    chk("R8 fs reset", fs_cal, 24'h800000);
    chk("R3 cmd readback", cmd_word, 16'hE0F9);
    chk("R10 clr stored no effect", data_word, 24'hA1B2C3);

    xfer(10, 3, 1); put(8'h33); put(8'h22); put(8'h11);
    chk("R5 decrement write", ofs_cal, 24'h112233);
    xfer(14, 3, 1); put(8'h77); put(8'h88); put(8'h99);
    chk("R5 decrement write fs", fs_cal, 24'h998877);

    xfer(4, 2, 1); put(8'hE2); put(8'h49);
    chk("R6 cmd write ascends", cmd_word, 16'hE249);
    chk("R10 crst stored no effect", ofs_cal, 24'h112233);

    xfer(2, 3, 0);
    get(v); chk("R5 read dec 0", v, 8'hC3);
    get(v); chk("R5 read dec 1", v, 8'hB2);
    get(v); chk("R5 read dec 2", v, 8'hA1);
    xfer(5, 2, 0);
    get(v); chk("R5 cmd read lsb", v, 8'h49);
    get(v); chk("R5 cmd read msb", v, 8'hE2);

    xfer(1, 3, 0);
    get(v); chk("R7 low 0", v, 8'hB2);
    get(v); chk("R7 low 1", v, 8'hA1);
    get(v); chk("R7 low hold", v, 8'hA1);

    xfer(5, 1, 1); put(8'h08);
    chk("R11 pending crst ofs", ofs_cal, 0);
    chk("R11 pending crst fs", fs_cal, 24'h800000);
    chk("R11 cmd after switch", cmd_word, 16'hE008);
    chk("R11 data kept", data_word, 24'hA1B2C3);

    xfer(5, 1, 1); put(8'h41);
    chk("R10 clr stored", cmd_word, 16'hE041);
    chk("R10 data kept", data_word, 24'hA1B2C3);
    xfer(5, 1, 1); put(8'h40);
    chk("R11 clr with switch", data_word, 0);
    chk("R11 cmd clr reads 0", cmd_word, 16'hE000);

    xfer(0, 3, 1); put(8'h0A); put(8'h0B); put(8'h0C);
    chk("R5 increment write", data_word, 24'h0A0B0C);
    xfer(5, 1, 1); put(8'h40);
    chk("R9 normal clr", data_word, 0);
    chk("R9 clr reads 0", cmd_word, 16'hE000);

    xfer(6, 1, 1); put(8'hFF);
    xfer(6, 1, 0); get(v); chk("R2 hole reads 0", v, 8'h00);
    xfer(15, 1, 0); get(v); chk("R2 top hole reads 0", v, 8'h00);

    xfer(14, 3, 1); put(8'h11); put(8'h22); put(8'h33);
    chk("R7 high hold fs", fs_cal, 24'h800011);
    xfer(13, 3, 0);
    get(v); chk("R7 high read 0", v, 8'h00);
    get(v); chk("R7 high read 1", v, 8'h11);
    get(v); chk("R7 high hold", v, 8'h00);

    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule